// File: doc/BRIEF.md
# I2C Byte Master

This block is a single-master I2C controller that moves one byte per command. A host or a hardware sequencer reaches it through a small register bus with 3-bit addresses and 8-bit data. It loads a 16-bit prescaler that sets the bus speed and sets the enable bit. It then places a byte in the transmit register and writes a command byte. The command byte can ask for a START, a byte write, a byte read and a STOP, in any useful combination. Both bus lines are open-drain. Each line has a pad input, a pad output tied to 0, and an active-low output enable. An enable of 1 releases the line to the pull-up, and an enable of 0 pulls it low.

A four-phase sequencer controls each bus segment. Its states are `SEG_IDLE`, `SEG_START`, `SEG_XFER` and `SEG_STOP`, and every segment lasts four quarter periods. The transitions are:

- `SEG_IDLE` to `SEG_START` when an accepted command has the START bit.
- `SEG_IDLE` to `SEG_XFER` when the command has no START bit but asks for a write or a read.
- `SEG_IDLE` to `SEG_STOP` when the command asks for a STOP only.
- `SEG_START` to `SEG_XFER`, `SEG_STOP` or `SEG_IDLE`, depending on the latched command.
- `SEG_XFER` to itself for each of nine bit slots. After the ninth slot it goes to `SEG_STOP` or `SEG_IDLE`.
- `SEG_STOP` to `SEG_IDLE`.
- Any state to `SEG_IDLE` when the core is disabled.

The status byte reports a transfer-in-progress flag and the acknowledge level taken from the bus. Software polls this byte to pace a sequence such as "address with START" followed by "data with STOP".

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, every register reads 0 (addresses 0 to 4) and both lines are released (`scl_oe_n` = 1 and `sda_oe_n` = 1).
- R2: A bus strobe is acknowledged one cycle later with a single-cycle `bus_ack`. The prescaler low byte (address 0), the prescaler high byte (address 1) and the enable bit 7 of control (address 2) read back what was written, for example 0x01F4 and 0x80.
- R3: While control bit 7 is 0, command writes are ignored. Status bit 1 stays 0 and both lines stay released. Clearing the bit releases both lines by the next cycle.
- R4: SDA changes only while SCL is low, with two exceptions. START pulls SDA low while SCL is high, and STOP releases SDA while SCL is high. Command bit 7 (START) puts a START before the byte, and bit 6 (STOP) puts a STOP after it.
- R5: Command bit 4 (write) sends the address-3 transmit byte MSB first and then releases SDA in the ninth slot. The level sampled in that slot is stored in status bit 7, where 0 means the slave acknowledged.
- R6: Status bit 1 rises only when a command is accepted. It falls once the whole sequence, STOP included, has finished, and each accepted command runs exactly once.
- R7: Command bit 5 (read) releases SDA for eight slots and shifts the sampled bits in MSB first. The result is readable at address 3. In the ninth slot the master drives command bit 3: 0 pulls SDA low (ACK) and 1 leaves it released (NACK).
- R8: One quarter period is P+1 clocks, where P is {address 1, address 0}. SCL stays high for 2·(P+1) clocks in every data or acknowledge slot.
- R9: A command written while status bit 1 is set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_stb | input | 1 | Access strobe, held until `bus_ack` |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access acknowledge |
| scl_o | output | 1 | SCL pad output value (always 0) |
| scl_oe_n | output | 1 | SCL output enable, 1 = released |
| sda_i | input | 1 | SDA pad input |
| sda_o | output | 1 | SDA pad output value (always 0) |
| sda_oe_n | output | 1 | SDA output enable, 1 = released |

## Verification
The bound checker watches these properties on every cycle:

- SDA moves while SCL is high only inside a START or STOP segment.
- The progress flag rises only after an accepted command.
- The bus acknowledge never lasts two cycles.
- SCL high time in data slots matches the prescaler.
- A disabled core releases both lines.

Other behaviour can only be shown by the bench's scenarios against its behavioural slave. These are the serialised byte values, the ACK and NACK level the slave sees, the ACK and NACK the master returns after a read, the byte assembled from slave data, and the absence of a STOP after a command written while busy.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned PRE_W  = 2 * DATA_W;
    localparam int unsigned SLOTS  = DATA_W + 1;
    localparam int unsigned BC_W   = $clog2(SLOTS + 1);

    localparam logic [ADDR_W-1:0] A_PRE_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_PRE_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMDST  = 3'd4;

    localparam int unsigned B_EN    = 7;
    localparam int unsigned B_STA   = 7;
    localparam int unsigned B_STO   = 6;
    localparam int unsigned B_RD    = 5;
    localparam int unsigned B_WR    = 4;
    localparam int unsigned B_NACK  = 3;
    localparam int unsigned B_RXACK = 7;
    localparam int unsigned B_TIP   = 1;

    typedef enum logic [1:0] {SEG_IDLE, SEG_START, SEG_XFER, SEG_STOP} seg_e;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
        logic nack;
    } cmd_t;
endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_stb,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    input  logic              busy,
    input  logic              rxack,
    input  logic [DATA_W-1:0] rxbyte,
    output logic [PRE_W-1:0]  presc,
    output logic              en,
    output logic [DATA_W-1:0] txbyte,
    output logic              go,
    output cmd_t              cmd
);
    logic [DATA_W-1:0] pre_lo, pre_hi, rd_mux, status;
    logic              access, cmd_any;

    assign presc   = {pre_hi, pre_lo};
    assign access  = bus_stb & ~bus_ack;
    assign cmd_any = bus_wdata[B_STA] | bus_wdata[B_STO] | bus_wdata[B_RD] | bus_wdata[B_WR];

    always_comb begin
        status          = '0;
        status[B_RXACK] = rxack;
        status[B_TIP]   = busy;
        case (bus_addr)
            A_PRE_LO: rd_mux = pre_lo;
            A_PRE_HI: rd_mux = pre_hi;
            A_CTRL:   rd_mux = {en, {(DATA_W-1){1'b0}}};
            A_DATA:   rd_mux = rxbyte;
            A_CMDST:  rd_mux = status;
            default:  rd_mux = '0;
        endcase
    end

    // R2: single-cycle acknowledge; R3/R9: commands accepted only when enabled and idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_lo    <= '0;
            pre_hi    <= '0;
            en        <= 1'b0;
            txbyte    <= '0;
            go        <= 1'b0;
            cmd       <= '0;
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack <= access;
            go      <= 1'b0;
            if (access) begin
                bus_rdata <= rd_mux;
                if (bus_we) begin
                    case (bus_addr)
                        A_PRE_LO: pre_lo <= bus_wdata;
                        A_PRE_HI: pre_hi <= bus_wdata;
                        A_CTRL:   en     <= bus_wdata[B_EN];
                        A_DATA:   txbyte <= bus_wdata;
                        A_CMDST: if (en && !busy && !go && cmd_any) begin
                            go  <= 1'b1;
                            cmd <= '{sta: bus_wdata[B_STA], sto: bus_wdata[B_STO],
                                     rd: bus_wdata[B_RD], wr: bus_wdata[B_WR],
                                     nack: bus_wdata[B_NACK]};
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  presc,
    input  logic              go,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] txbyte,
    input  logic              sda_i,
    output logic              busy,
    output logic              rxack,
    output logic [DATA_W-1:0] rxbyte,
    output logic              scl_oe_n,
    output logic              sda_oe_n,
    output seg_e              seg
);
    localparam logic [BC_W-1:0] LAST_SLOT = BC_W'(SLOTS - 1);

    seg_e              st, st_n;
    logic [1:0]        ph, ph_n;
    logic [BC_W-1:0]   bc, bc_n;
    logic [PRE_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    cmd_t              lat;
    logic              tick, step, wr_sel, msb_sel, scl_q, sda_q;

    assign busy     = (st != SEG_IDLE);
    assign seg      = st;
    assign rxbyte   = sh;
    assign scl_oe_n = scl_q;
    assign sda_oe_n = sda_q;
    assign tick     = busy && (cnt == presc);          // R8: quarter = presc+1 clocks
    assign wr_sel   = (st == SEG_IDLE) ? cmd.wr : lat.wr;
    assign msb_sel  = (st == SEG_IDLE) ? txbyte[DATA_W-1] : sh[DATA_W-1];

    // next segment, phase and slot
    always_comb begin
        st_n = st;
        ph_n = ph;
        bc_n = bc;
        step = 1'b0;
        unique case (st)
            SEG_IDLE: if (go) begin
                step = 1'b1;
                ph_n = 2'd0;
                bc_n = '0;
                st_n = cmd.sta ? SEG_START : ((cmd.rd || cmd.wr) ? SEG_XFER : SEG_STOP);
            end
            default: if (tick) begin
                step = 1'b1;
                if (ph != 2'd3) begin
                    ph_n = ph + 2'd1;
                end else begin
                    ph_n = 2'd0;
                    unique case (st)
                        SEG_START: st_n = (lat.rd || lat.wr) ? SEG_XFER
                                        : (lat.sto ? SEG_STOP : SEG_IDLE);
                        SEG_XFER: begin
                            if (bc != LAST_SLOT) bc_n = bc + 1'b1;
                            else st_n = lat.sto ? SEG_STOP : SEG_IDLE;
                        end
                        default: st_n = SEG_IDLE;
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SEG_IDLE;
            ph  <= 2'd0;
            bc  <= '0;
            cnt <= '0;
        end else if (!en) begin
            st  <= SEG_IDLE;
            ph  <= 2'd0;
            bc  <= '0;
            cnt <= '0;
        end else begin
            st  <= st_n;
            ph  <= ph_n;
            bc  <= bc_n;
            cnt <= (!busy || tick) ? '0 : cnt + 1'b1;
        end
    end

    // line and data outputs, one action per phase entry (R4, R5, R7)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            sh    <= '0;
            rxack <= 1'b0;
            lat   <= '0;
        end else if (!en) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            if (st == SEG_IDLE && go) begin
                lat <= cmd;
                sh  <= txbyte;
            end
            if (step) begin
                unique case (st_n)
                    SEG_START: unique case (ph_n)
                        2'd0: sda_q <= 1'b1;
                        2'd1: scl_q <= 1'b1;
                        2'd2: sda_q <= 1'b0;
                        default: scl_q <= 1'b0;
                    endcase
                    SEG_XFER: unique case (ph_n)
                        2'd0: if (bc_n == LAST_SLOT) sda_q <= wr_sel ? 1'b1 : lat.nack;
                              else sda_q <= wr_sel ? msb_sel : 1'b1;
                        2'd1: scl_q <= 1'b1;
                        2'd2: if (bc_n != LAST_SLOT) sh <= {sh[DATA_W-2:0], sda_i};
                              else if (lat.wr) rxack <= sda_i;
                        default: scl_q <= 1'b0;
                    endcase
                    SEG_STOP: unique case (ph_n)
                        2'd0: sda_q <= 1'b0;
                        2'd1: scl_q <= 1'b1;
                        2'd2: sda_q <= 1'b1;
                        default: ;
                    endcase
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_stb,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              scl_o,
    output logic              scl_oe_n,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe_n
);
    logic [PRE_W-1:0]  presc;
    logic [DATA_W-1:0] txbyte, rxbyte;
    logic              en, go, busy, rxack;
    cmd_t              cmd;
    seg_e              seg;

    assign scl_o = 1'b0;
    assign sda_o = 1'b0;

    i2cm_regs i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_stb(bus_stb), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .rxack(rxack), .rxbyte(rxbyte), .presc(presc), .en(en),
        .txbyte(txbyte), .go(go), .cmd(cmd)
    );

    i2cm_engine i_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .presc(presc), .go(go), .cmd(cmd),
        .txbyte(txbyte), .sda_i(sda_i), .busy(busy), .rxack(rxack), .rxbyte(rxbyte),
        .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .seg(seg)
    );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             go,
    input logic             busy,
    input logic             bus_ack,
    input logic             scl_oe_n,
    input logic             sda_oe_n,
    input logic [PRE_W-1:0] presc,
    input seg_e             seg
);
    logic [PRE_W+1:0] hi_cnt, hi_span;

    assign hi_span = ({2'b00, presc} + 1'b1) << 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt <= '0;
        else        hi_cnt <= scl_oe_n ? hi_cnt + 1'b1 : '0;
    end

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack); // R2

    AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_oe_n && sda_oe_n)); // R3

    AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (scl_oe_n && $past(scl_oe_n) && (sda_oe_n != $past(sda_oe_n)))
        |-> (seg == SEG_START || seg == SEG_STOP)); // R4

    AST_TIP_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go)); // R6

    AST_SCL_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_oe_n) && seg == SEG_XFER) |-> (hi_cnt == hi_span)); // R8
endmodule

bind i2c_byte_master i2cm_checker i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .go(go), .busy(busy), .bus_ack(bus_ack),
    .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .presc(presc), .seg(seg)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] b_addr = '0;
    logic [7:0] b_wdata = '0;
    logic       b_we = 1'b0, b_stb = 1'b0;
    logic [7:0] b_rdata;
    logic       b_ack, scl_o, scl_oe_n, sda_o, sda_oe_n, sda_i;
    logic       s_pull = 1'b0;
    logic       scl_line, sda_line;

    int total = 0, bad = 0;
    int n_start = 0, n_stop = 0, last_hi = 0, hi_run = 0, ack_lat = 0;
    logic [7:0] exp_q[$];
    localparam logic [6:0] SADDR = 7'h3A;
    localparam logic [7:0] RDAT  = 8'hC3;

    always #2.5 clk = ~clk;

    assign scl_line = scl_oe_n;
    assign sda_line = sda_oe_n & ~s_pull;
    assign sda_i    = sda_line;

    i2c_byte_master i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_we(b_we),
        .bus_stb(b_stb), .bus_rdata(b_rdata), .bus_ack(b_ack), .scl_o(scl_o),
        .scl_oe_n(scl_oe_n), .sda_i(sda_i), .sda_o(sda_o), .sda_oe_n(sda_oe_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural slave and scoreboard monitor
    logic pscl = 1'b1, psda = 1'b1, match = 1'b0, rdmode = 1'b0, mack = 1'b0;
    int   bitn = 0, smode = 0;  // 0 idle, 1 address, 2 write, 3 read
    logic [7:0] ssh = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && pscl && psda && !sda_line) begin
                n_start++; smode = 1; bitn = 0; s_pull = 1'b0;
            end else if (scl_line && pscl && !psda && sda_line) begin
                n_stop++; smode = 0; s_pull = 1'b0;
            end else if (scl_line && !pscl) begin
                hi_run = 0;
                if (smode != 0) begin
                    if (bitn < 8) ssh = {ssh[6:0], sda_line};
                    else if (smode == 3) mack = sda_line;
                    bitn++;
                end
            end else if (!scl_line && pscl && smode != 0) begin
                last_hi = hi_run;
                if (bitn == 8) begin
                    if (smode == 3) s_pull = 1'b0;
                    else begin
                        if (exp_q.size() == 0) chk("R5 unexpected byte", ssh, 0);
                        else chk("R5 byte on bus", ssh, exp_q.pop_front());
                        if (smode == 1) begin match = (ssh[7:1] == SADDR); rdmode = ssh[0]; end
                        s_pull = (smode == 1) ? match : 1'b1;
                    end
                end else if (bitn == 9) begin
                    bitn = 0; s_pull = 1'b0;
                    if (smode == 1) begin
                        smode = !match ? 0 : (rdmode ? 3 : 2);
                        if (smode == 3) s_pull = ~RDAT[7];
                    end else if (smode == 3) begin
                        if (!mack) s_pull = ~RDAT[7];
                        else smode = 0;
                    end
                end else if (smode == 3 && bitn > 0) begin
                    s_pull = ~RDAT[7 - bitn];
                end
            end
            if (scl_line) hi_run++;
        end
        pscl = scl_line;
        psda = sda_line;
    end

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        int waited = 0;
        @(negedge clk);
        b_addr = a; b_wdata = d; b_we = 1'b1; b_stb = 1'b1;
        do begin @(negedge clk); waited++; end while (!b_ack && waited < 10);
        b_stb = 1'b0; b_we = 1'b0;
        ack_lat = waited;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        int waited = 0;
        @(negedge clk);
        b_addr = a; b_we = 1'b0; b_stb = 1'b1;
        do begin @(negedge clk); waited++; end while (!b_ack && waited < 10);
        d = b_rdata;
        b_stb = 1'b0;
        ack_lat = waited;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(3'd4, s);
            if (!s[1]) return;
        end
        chk("R6 transfer never ended", 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int released;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 scl released", scl_oe_n, 1);
        chk("R1 sda released", sda_oe_n, 1);
        for (int a = 0; a < 5; a++) begin
            bus_rd(3'(a), v);
            chk("R1 register reset", v, 0);
        end

        // R3 disabled core ignores commands
        bus_wr(3'd3, 8'h74);
        bus_wr(3'd4, 8'h90);
        released = 1;
        repeat (40) begin @(negedge clk); if (!scl_oe_n || !sda_oe_n) released = 0; end
        chk("R3 lines released while disabled", released, 1);
        bus_rd(3'd4, v);
        chk("R3 status idle while disabled", v, 0);
        chk("R3 no START while disabled", n_start, 0);

        // R2 register readback and ack latency
        bus_wr(3'd0, 8'hF4);
        chk("R2 ack latency", ack_lat, 1);
        bus_wr(3'd1, 8'h01);
        bus_wr(3'd2, 8'h80);
        bus_rd(3'd0, v); chk("R2 prescaler low", v, 8'hF4);
        chk("R2 read ack latency", ack_lat, 1);
        bus_rd(3'd1, v); chk("R2 prescaler high", v, 8'h01);
        bus_rd(3'd2, v); chk("R2 control", v, 8'h80);
        bus_wr(3'd0, 8'h02);
        bus_wr(3'd1, 8'h00);

        // R5/R6 address write with START
        exp_q.push_back(8'h74);
        bus_wr(3'd3, 8'h74);
        bus_wr(3'd4, 8'h90);
        bus_rd(3'd4, v); chk("R6 tip set after command", v[1], 1);
        wait_idle();
        bus_rd(3'd4, v); chk("R5 slave acked address", v, 8'h00);
        chk("R4 one START", n_start, 1);

        // R4/R8 data write with STOP
        exp_q.push_back(8'hA5);
        bus_wr(3'd3, 8'hA5);
        bus_wr(3'd4, 8'h50);
        wait_idle();
        bus_rd(3'd4, v); chk("R5 slave acked data", v, 8'h00);
        chk("R4 STOP after data", n_stop, 1);
        chk("R8 SCL high clocks (P=2)", last_hi, 6);
        chk("R4 lines released after STOP", {scl_oe_n, sda_line}, 2'b11);

        // R5 unmatched address -> NACK recorded
        exp_q.push_back(8'hAA);
        bus_wr(3'd3, 8'hAA);
        bus_wr(3'd4, 8'hD0);
        wait_idle();
        bus_rd(3'd4, v); chk("R5 NACK in status bit 7", v, 8'h80);
        chk("R6 STOP ran once", n_stop, 2);

        // R7 read with NACK then STOP
        exp_q.push_back(8'h75);
        bus_wr(3'd3, 8'h75);
        bus_wr(3'd4, 8'h90);
        wait_idle();
        bus_wr(3'd4, 8'h68);
        wait_idle();
        bus_rd(3'd3, v); chk("R7 read byte", v, RDAT);
        chk("R7 master NACK", mack, 1);
        chk("R7 STOP after read", n_stop, 3);

        // R7 read with ACK, separate STOP command
        exp_q.push_back(8'h75);
        bus_wr(3'd3, 8'h75);
        bus_wr(3'd4, 8'h90);
        wait_idle();
        bus_wr(3'd4, 8'h20);
        wait_idle();
        bus_rd(3'd3, v); chk("R7 read byte (ACK)", v, RDAT);
        chk("R7 master ACK", mack, 0);
        bus_wr(3'd4, 8'h40);
        wait_idle();
        chk("R4 STOP-only command", n_stop, 4);

        // R9 command while busy ignored
        exp_q.push_back(8'h74);
        bus_wr(3'd3, 8'h74);
        bus_wr(3'd4, 8'h90);
        bus_wr(3'd4, 8'h50);
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R9 SCL still held low", scl_oe_n, 0);
        chk("R9 no STOP from ignored command", n_stop, 4);
        bus_wr(3'd4, 8'h40);
        wait_idle();
        chk("R9 later STOP accepted", n_stop, 5);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        // R3 disable releases lines
        bus_wr(3'd2, 8'h00);
        @(negedge clk);
        chk("R3 released after disable", {scl_oe_n, sda_oe_n}, 2'b11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule